// File: doc/BRIEF.md
# Two-Level Network Output Port Selector

This block decides which output port of a switch a packet header should leave through. The network is built from groups of switches. Every switch in a group connects directly to the others in its group over local links, and groups connect to each other over global links. A header names a destination group and a destination switch. The block compares the destination group with its own group number. It then reads one of two route tables: one for destinations inside the group, and one for destinations in other groups.

Headers come from two places: the local host interface (injection) and the network ports (transit). Each of these two classes has its own pair of tables. The block supports several routing modes. A packet can go straight to its destination group over one fixed path, or be spread over several direct paths. It can also detour through an intermediate group. At injection, that intermediate group is picked by a per-source round-robin pointer or by a pseudo-random generator, or it is supplied by software in the header. Along the way, the header's visited flag is set once the packet reaches the intermediate group, and from then on the packet is routed directly. Because the paths differ, packets of one message may arrive out of order.

The tables are synchronous memories. A lookup therefore gives its result on the clock edge after the header is accepted. Table writes take priority over lookups.

Top module: `hrs_route_sel`

## Requirements
- R1: `out_valid` is high in exactly the cycles that follow a cycle in which `hdr_valid` and `hdr_ready` were both high. After reset it is low.
- R2: `hdr_ready` is low while `rst` is high or `tw_en` is high, and high otherwise.
- R3: When `hdr_dst_grp` equals `my_grp`, the port comes from the intra-group table of the header's class, at address `hdr_dst_sw`. `out_mid_grp` and `out_visited` repeat the header's values. This holds in every mode.
- R4: In mode 0 (single direct), and in modes 5 to 7 (treated as mode 0), a header for another group takes the inter-group table entry at address `dst_grp*NUM_WAYS + 0`.
- R5: In mode 1 (multiple direct), the inter-group address is `dst_grp*NUM_WAYS + (dst_sw mod NUM_WAYS)`.
- R6: `tw_tbl` bit 1 selects the table set (0 = injection, 1 = transit), and `tw_tbl` bit 0 selects the kind (0 = intra-group, 1 = inter-group). A header uses the transit set when `hdr_inject` is 0.
- R7: Mode 2 applies to an injected header for another group that has not yet visited an intermediate group. The block takes the k-th group in ascending order, skipping `my_grp` and `hdr_dst_grp`, where k is the pointer of source `hdr_src`. That pointer starts at 0, advances by one for each such packet, and wraps after NUM_GROUPS-2 packets. The port is the inter-group entry of that group at way 0, `out_mid_grp` is that group, and `out_visited` is 0.
- R8: Mode 3 applies to the same kind of header as R7 but takes k = L mod (NUM_GROUPS-2). L is a 16-bit LFSR: it is seeded with `LFSR_SEED`, it shifts left, and its new bit 0 is the XOR of bits 15, 13, 12 and 10. It steps once per such packet.
- R9: Mode 4, and transit headers in modes 2 to 4, take the intermediate group from `hdr_mid_grp` and route toward it, as long as it differs from `my_grp`.
- R10: A header in modes 2 to 4 whose intermediate group equals `my_grp` leaves with `out_visited` set and is routed toward `hdr_dst_grp`. A header arriving with its visited flag set is always routed toward `hdr_dst_grp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| my_grp | input | GW | Group number of this switch |
| hdr_valid | input | 1 | Header present |
| hdr_ready | output | 1 | Header can be taken this cycle |
| hdr_inject | input | 1 | 1 = header from local host, 0 = transit |
| hdr_src | input | SRCW | Injecting source index (round-robin pointer select) |
| hdr_mode | input | 3 | Routing mode code |
| hdr_dst_grp | input | GW | Destination group |
| hdr_dst_sw | input | SWW | Destination switch within group |
| hdr_mid_grp | input | GW | Intermediate group carried in header |
| hdr_visited | input | 1 | Intermediate group already reached |
| tw_en | input | 1 | Table write strobe |
| tw_tbl | input | 2 | Table select: bit1 set, bit0 kind |
| tw_addr | input | AW | Table entry address |
| tw_data | input | PW | Output port stored in entry |
| out_valid | output | 1 | Lookup result valid |
| out_port | output | PW | Selected output port |
| out_mid_grp | output | GW | Intermediate group to write into header |
| out_visited | output | 1 | Visited flag to write into header |

## Verification
The hardest states to reach are those where a round-robin pointer wraps, and those where the LFSR remainder points at the slot just past the skipped groups. Both need many injected detour packets from the same source, sent toward varying destination groups. The stimulus sends thousands of headers with random mode, source and group, and it biases the destination group and the header's intermediate group toward the switch's own group. Because of that bias, the local-delivery and reached-intermediate cases occur often. Table writes are placed at random between headers, with `hdr_valid` held high, so that the blocked-accept cycle is exercised. Midway through the run the switch's own group is changed.

// File: rtl/hrs_pkg.sv
package hrs_pkg;
  typedef enum logic [2:0] {
    MD_SINGLE  = 3'd0,
    MD_MULTI   = 3'd1,
    MD_IND_RR  = 3'd2,
    MD_IND_RND = 3'd3,
    MD_IND_SW  = 3'd4
  } route_mode_e;

  localparam int TBL_KIND_BIT = 0;  // 1 = inter-group table
  localparam int TBL_SET_BIT  = 1;  // 1 = transit table set
endpackage

// File: rtl/hrs_table_ram.sv
module hrs_table_ram #(
  parameter int DW    = 4,
  parameter int AW    = 4,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       we,
  input  logic [AW-1:0]              waddr,
  input  logic [DW-1:0]              wdata,
  input  logic [$clog2(DEPTH)-1:0]   raddr,
  output logic [DW-1:0]              rdata
);
  localparam int IW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (32'(waddr) < DEPTH)) mem[waddr[IW-1:0]] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/hrs_mid_pick.sv
module hrs_mid_pick #(
  parameter int          NUM_GROUPS = 8,
  parameter int          NUM_SRC    = 4,
  parameter logic [15:0] LFSR_SEED  = 16'hACE1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [$clog2(NUM_SRC)-1:0]  src,
  input  logic [$clog2(NUM_GROUPS)-1:0] my_grp,
  input  logic [$clog2(NUM_GROUPS)-1:0] dst_grp,
  input  logic                        adv_rr,
  input  logic                        adv_rnd,
  output logic [$clog2(NUM_GROUPS)-1:0] rr_grp,
  output logic [$clog2(NUM_GROUPS)-1:0] rnd_grp
);
  localparam int GW   = $clog2(NUM_GROUPS);
  localparam int NMID = NUM_GROUPS - 2;

  logic [GW-1:0] rr_q [NUM_SRC];
  logic [15:0]   lfsr_q;
  logic          lfsr_fb;
  logic [GW-1:0] rr_k, rnd_k;

  // map slot k onto the groups left after removing x and y
  function automatic logic [GW-1:0] skip_two(input logic [GW-1:0] k,
                                             input logic [GW-1:0] x,
                                             input logic [GW-1:0] y);
    logic [GW-1:0] lo, hi, c;
    lo = (x < y) ? x : y;
    hi = (x < y) ? y : x;
    c  = k;
    if (c >= lo) c = c + 1'b1;
    if (c >= hi) c = c + 1'b1;
    return c;
  endfunction

  assign lfsr_fb = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];
  assign rr_k    = rr_q[src];
  assign rnd_k   = GW'(lfsr_q % 16'(NMID));
  assign rr_grp  = skip_two(rr_k, my_grp, dst_grp);
  assign rnd_grp = skip_two(rnd_k, my_grp, dst_grp);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SRC; i++) rr_q[i] <= '0;
      lfsr_q <= LFSR_SEED;
    end else begin
      if (adv_rr) rr_q[src] <= (rr_q[src] == GW'(NMID - 1)) ? '0 : rr_q[src] + 1'b1;
      if (adv_rnd) lfsr_q <= {lfsr_q[14:0], lfsr_fb};
    end
  end

  AST_RR_BOUND: assert property (@(posedge clk) disable iff (rst) 32'(rr_k) < NMID); // R7
  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (rst) lfsr_q != 16'd0); // R8
  AST_MID_EXCLUDE: assert property (@(posedge clk) disable iff (rst)
    (my_grp != dst_grp) |-> (rr_grp != my_grp && rr_grp != dst_grp &&
                             rnd_grp != my_grp && rnd_grp != dst_grp)); // R7
endmodule

// File: rtl/hrs_route_sel.sv
module hrs_route_sel
  import hrs_pkg::*;
#(
  parameter int          NUM_GROUPS = 8,
  parameter int          NUM_SW     = 4,
  parameter int          NUM_PORTS  = 16,
  parameter int          NUM_SRC    = 4,
  parameter int          NUM_WAYS   = 2,
  parameter logic [15:0] LFSR_SEED  = 16'hACE1,
  localparam int GW   = $clog2(NUM_GROUPS),
  localparam int SWW  = $clog2(NUM_SW),
  localparam int PW   = $clog2(NUM_PORTS),
  localparam int SRCW = $clog2(NUM_SRC),
  localparam int IFD  = NUM_GROUPS * NUM_WAYS,
  localparam int IFW  = $clog2(IFD),
  localparam int AW   = (SWW > IFW) ? SWW : IFW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [GW-1:0]   my_grp,
  input  logic            hdr_valid,
  output logic            hdr_ready,
  input  logic            hdr_inject,
  input  logic [SRCW-1:0] hdr_src,
  input  logic [2:0]      hdr_mode,
  input  logic [GW-1:0]   hdr_dst_grp,
  input  logic [SWW-1:0]  hdr_dst_sw,
  input  logic [GW-1:0]   hdr_mid_grp,
  input  logic            hdr_visited,
  input  logic            tw_en,
  input  logic [1:0]      tw_tbl,
  input  logic [AW-1:0]   tw_addr,
  input  logic [PW-1:0]   tw_data,
  output logic            out_valid,
  output logic [PW-1:0]   out_port,
  output logic [GW-1:0]   out_mid_grp,
  output logic            out_visited
);
  logic          accept, far, detour, reached, is_rr, is_rnd;
  logic [GW-1:0] rr_grp, rnd_grp, mid_c, tgt;
  logic [IFW-1:0] way_n, inter_addr;
  logic          sel_transit, sel_local;
  logic [PW-1:0] intra_rd [2];
  logic [PW-1:0] inter_rd [2];

  assign hdr_ready = !rst && !tw_en;
  assign accept    = hdr_valid && hdr_ready;

  assign is_rr   = (hdr_mode == MD_IND_RR);
  assign is_rnd  = (hdr_mode == MD_IND_RND);
  assign far     = (hdr_dst_grp != my_grp);
  assign detour  = (is_rr || is_rnd || hdr_mode == MD_IND_SW) && !hdr_visited && far;

  always_comb begin
    mid_c = hdr_mid_grp;
    if (hdr_inject && is_rr)  mid_c = rr_grp;
    if (hdr_inject && is_rnd) mid_c = rnd_grp;
  end

  assign reached    = detour && (mid_c == my_grp);
  assign tgt        = (detour && !reached) ? mid_c : hdr_dst_grp;
  assign way_n      = (hdr_mode == MD_MULTI) ? IFW'(32'(hdr_dst_sw) % NUM_WAYS) : '0;
  assign inter_addr = IFW'(32'(tgt) * NUM_WAYS) + way_n;

  hrs_mid_pick #(
    .NUM_GROUPS (NUM_GROUPS),
    .NUM_SRC    (NUM_SRC),
    .LFSR_SEED  (LFSR_SEED)
  ) u_mid (
    .clk     (clk),
    .rst     (rst),
    .src     (hdr_src),
    .my_grp  (my_grp),
    .dst_grp (hdr_dst_grp),
    .adv_rr  (accept && hdr_inject && detour && is_rr),
    .adv_rnd (accept && hdr_inject && detour && is_rnd),
    .rr_grp  (rr_grp),
    .rnd_grp (rnd_grp)
  );

  for (genvar s = 0; s < 2; s++) begin : g_set
    hrs_table_ram #(.DW(PW), .AW(AW), .DEPTH(NUM_SW)) u_intra (
      .clk   (clk),
      .we    (tw_en && tw_tbl[TBL_SET_BIT] == 1'(s) && !tw_tbl[TBL_KIND_BIT]),
      .waddr (tw_addr),
      .wdata (tw_data),
      .raddr (hdr_dst_sw),
      .rdata (intra_rd[s])
    );
    hrs_table_ram #(.DW(PW), .AW(AW), .DEPTH(IFD)) u_inter (
      .clk   (clk),
      .we    (tw_en && tw_tbl[TBL_SET_BIT] == 1'(s) && tw_tbl[TBL_KIND_BIT]),
      .waddr (tw_addr),
      .wdata (tw_data),
      .raddr (inter_addr),
      .rdata (inter_rd[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      sel_transit <= 1'b0;
      sel_local   <= 1'b0;
      out_mid_grp <= '0;
      out_visited <= 1'b0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        sel_transit <= !hdr_inject;
        sel_local   <= (tgt == my_grp);
        out_mid_grp <= detour ? mid_c : hdr_mid_grp;
        out_visited <= hdr_visited || reached;
      end
    end
  end

  assign out_port = sel_transit ? (sel_local ? intra_rd[1] : inter_rd[1])
                                : (sel_local ? intra_rd[0] : inter_rd[0]);

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (hdr_valid && hdr_ready) |=> out_valid); // R1
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !(hdr_valid && hdr_ready) |=> !out_valid); // R1
  AST_WRITE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    tw_en |-> !hdr_ready); // R2
  AST_LOCAL_PASS: assert property (@(posedge clk) disable iff (rst)
    (accept && hdr_dst_grp == my_grp) |=>
      (out_mid_grp == $past(hdr_mid_grp) && out_visited == $past(hdr_visited))); // R3
  AST_VISITED_STICKY: assert property (@(posedge clk) disable iff (rst)
    (accept && hdr_visited) |=> out_visited); // R10
endmodule

// File: tb/hrs_route_sel_bench.sv
module hrs_route_sel_bench;
  localparam int NG = 8, NSW = 4, NP = 16, NSRC = 4, NW = 2;
  localparam logic [15:0] SEED = 16'hACE1;
  localparam int GW = 3, SWW = 2, PW = 4, SRCW = 2, AW = 4;

  logic clk = 0, rst = 1;
  logic [GW-1:0] my_grp = 3'd2;
  logic hdr_valid = 0, hdr_inject = 0, hdr_visited = 0;
  logic [SRCW-1:0] hdr_src = 0;
  logic [2:0] hdr_mode = 0;
  logic [GW-1:0] hdr_dst_grp = 0, hdr_mid_grp = 0;
  logic [SWW-1:0] hdr_dst_sw = 0;
  logic tw_en = 0;
  logic [1:0] tw_tbl = 0;
  logic [AW-1:0] tw_addr = 0;
  logic [PW-1:0] tw_data = 0;
  logic hdr_ready, out_valid, out_visited;
  logic [PW-1:0] out_port;
  logic [GW-1:0] out_mid_grp;

  always #10 clk = ~clk;

  hrs_route_sel u_hrs_route_sel (
    .clk(clk), .rst(rst), .my_grp(my_grp), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .hdr_inject(hdr_inject), .hdr_src(hdr_src), .hdr_mode(hdr_mode),
    .hdr_dst_grp(hdr_dst_grp), .hdr_dst_sw(hdr_dst_sw), .hdr_mid_grp(hdr_mid_grp),
    .hdr_visited(hdr_visited), .tw_en(tw_en), .tw_tbl(tw_tbl), .tw_addr(tw_addr),
    .tw_data(tw_data), .out_valid(out_valid), .out_port(out_port),
    .out_mid_grp(out_mid_grp), .out_visited(out_visited));

  int vecs = 0, errs = 0;
  bit done = 0;
  int intra_m [2][NSW];
  int inter_m [2][NG*NW];
  int rr_m [NSRC];
  logic [15:0] lfsr_m;
  bit exp_v = 0, exp_vis = 0;
  int exp_port = 0, exp_mid = 0;
  string exp_tag = "R1";

  function automatic int nth_other(int k, int a, int b);
    int n = 0;
    for (int g = 0; g < NG; g++) begin
      if (g != a && g != b) begin
        if (n == k) return g;
        n++;
      end
    end
    return -1;
  endfunction

  // behavioural reference model
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSRC; i++) rr_m[i] = 0;
      lfsr_m = SEED;
      exp_v <= 0;
    end else begin
      if (tw_en) begin
        if (tw_tbl[0]) begin
          if (tw_addr < NG*NW) inter_m[tw_tbl[1]][tw_addr] = tw_data;
        end else if (tw_addr < NSW) intra_m[tw_tbl[1]][tw_addr] = tw_data;
      end
      exp_v <= hdr_valid && !tw_en;
      if (hdr_valid && !tw_en) begin
        int set, tgt, mid, way, m;
        bit ind, vis;
        string tag;
        set = hdr_inject ? 0 : 1;
        m = hdr_mode;
        mid = hdr_mid_grp;
        vis = hdr_visited;
        ind = (m >= 2 && m <= 4) && !hdr_visited && (hdr_dst_grp != my_grp);
        tag = hdr_inject ? "R4" : "R6";
        if (m == 1) tag = "R5";
        if (ind) begin
          tag = "R9";
          if (hdr_inject && m == 2) begin
            mid = nth_other(rr_m[hdr_src], my_grp, hdr_dst_grp);
            rr_m[hdr_src] = (rr_m[hdr_src] + 1) % (NG - 2);
            tag = "R7";
          end
          if (hdr_inject && m == 3) begin
            mid = nth_other(int'(lfsr_m) % (NG - 2), my_grp, hdr_dst_grp);
            lfsr_m = {lfsr_m[14:0], lfsr_m[15] ^ lfsr_m[13] ^ lfsr_m[12] ^ lfsr_m[10]};
            tag = "R8";
          end
        end
        if (ind && mid == my_grp) begin vis = 1; tag = "R10"; end
        if (hdr_visited) tag = "R10";
        tgt = (ind && !vis) ? mid : hdr_dst_grp;
        way = (m == 1) ? hdr_dst_sw % NW : 0;
        if (tgt == my_grp) begin
          exp_port <= intra_m[set][hdr_dst_sw];
          if (hdr_dst_grp == my_grp) tag = "R3";
        end else exp_port <= inter_m[set][tgt*NW + way];
        exp_mid <= ind ? mid : hdr_mid_grp;
        exp_vis <= vis;
        exp_tag <= tag;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      vecs++;
      if (hdr_ready !== !tw_en) begin
        errs++;
        $display("FAIL R2 hdr_ready=%0b expected %0b", hdr_ready, !tw_en);
      end
      if (out_valid !== exp_v) begin
        errs++;
        $display("FAIL R1 out_valid=%0b expected %0b", out_valid, exp_v);
      end else if (exp_v && (out_port !== PW'(exp_port) || out_mid_grp !== GW'(exp_mid) ||
                             out_visited !== exp_vis)) begin
        errs++;
        $display("FAIL %s port/mid/vis=%0d/%0d/%0b expected %0d/%0d/%0b", exp_tag,
                 out_port, out_mid_grp, out_visited, exp_port, exp_mid, exp_vis);
      end
    end
  end

  task automatic put_entry(input int tbl, input int addr, input int data);
    tw_en = 1; tw_tbl = 2'(tbl); tw_addr = AW'(addr); tw_data = PW'(data);
    @(posedge clk); #1;
    tw_en = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(posedge clk); #1;  // R1: reset state compared at the next negedge
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < NSW; a++) put_entry(s*2, a, $urandom % NP);
      for (int a = 0; a < NG*NW; a++) put_entry(s*2 + 1, a, $urandom % NP);
    end
    for (int i = 0; i < 6000; i++) begin
      if (i == 3000) my_grp = 3'd5;
      tw_en = ($urandom % 10) == 0;  // R2: writes with headers pending
      tw_tbl = 2'($urandom);
      tw_addr = AW'($urandom);
      tw_data = PW'($urandom);
      hdr_valid = ($urandom % 4) != 0;
      hdr_inject = 1'($urandom);
      hdr_src = SRCW'($urandom);
      hdr_mode = 3'($urandom);
      hdr_dst_grp = (($urandom % 4) == 0) ? my_grp : GW'($urandom);
      hdr_dst_sw = SWW'($urandom);
      hdr_mid_grp = (($urandom % 3) == 0) ? my_grp : GW'($urandom);
      hdr_visited = ($urandom % 5) == 0;
      @(posedge clk); #1;
    end
    hdr_valid = 0; tw_en = 0;
    repeat (3) @(posedge clk);
    #1;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule